// File: doc/BRIEF.md
# Walking-Pattern RAM Self-Test Engine

This block tests a single-port synchronous RAM whose words are 16 bits wide and whose depth is set by a parameter (4096 words by default). The host pulses a start input. The engine then takes over the RAM port and makes two sweeps over every word. In the first sweep each word is written with its own address and then read back and compared. In the second sweep each word is written with the bitwise complement of its address and then compared the same way.

While the engine owns the RAM, host accesses are dropped and `busy` stays high. When the test completes, a one-cycle completion pulse fires, which can drive a self-test-complete interrupt. A sticky done flag and a fail flag report the result, where a fail flag of 1 means at least one mismatch. The address, expected word and read word of the first mismatch are held for the host to read.

The test always runs to the end and does not restore the RAM. Afterwards every word holds the complement of its address, whether the test passed or failed.

Top module: `ram_walk_bist`

## Requirements
- R1: After reset `busy`, `donePulse`, `doneFlag` and `failFlag` are 0, and `diagAddr`, `diagExp` and `diagAct` are 0.
- R2: A high `startCmd` sampled while idle sets `busy` on that same clock edge. A high `startCmd` while `busy` is high is ignored and does not change the run length.
- R3: `busy` stays high for exactly 10 × DEPTH cycles per run, where DEPTH = 2^ADDR_W. Each write sweep takes 2 cycles per word and each read-compare sweep takes 3 cycles per word.
- R4: `donePulse` is high for exactly one cycle, which is the first cycle in which `busy` is low again. `doneFlag` is set at that point and stays set until the next accepted start.
- R5: After a run, every word at address a reads back as ~a, where a is zero-extended to DATA_W and then inverted across all DATA_W bits. This holds whether the run passed or failed.
- R6: `failFlag` is 1 after a run exactly when some read-back word differed from the word written for it in that sweep. It stays set until the next accepted start.
- R7: On the first mismatch of a run, `diagAddr` holds the word address, `diagExp` holds the expected word, and `diagAct` holds the word that was read. Later mismatches leave these unchanged. An accepted start clears all three to 0.
- R8: While `busy` is high, host reads and writes never reach the RAM port. While idle, `hostEn` with `hostWe` writes `hostWdata`. A host read returns the word on `hostRdata` one cycle after it is issued.
- R9: During a run, the engine never asserts a RAM write strobe in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Start request (host control bit) |
| hostEn | input | 1 | Host RAM access enable |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data, one cycle after the request |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | ADDR_W | RAM address |
| ramWdata | output | DATA_W | RAM write data |
| ramRdata | input | DATA_W | RAM read data, registered one cycle after the address |
| busy | output | 1 | Test in progress; host access refused |
| donePulse | output | 1 | One-cycle completion pulse |
| doneFlag | output | 1 | Sticky completion status |
| failFlag | output | 1 | Sticky result: 1 = fail |
| diagAddr | output | ADDR_W | Address of the first mismatch |
| diagExp | output | DATA_W | Expected word at the first mismatch |
| diagAct | output | DATA_W | Word read at the first mismatch |

## Verification
`busy` is due one edge after the start is sampled. It then lasts 10 × DEPTH cycles, which the bench counts on falling edges and compares against that figure. The completion pulse, `doneFlag`, `failFlag` and the diagnostic words are checked on the first falling edge with `busy` low and again one edge later. Host reads are checked one falling edge after the request, which matches the RAM's single register stage.

Stuck-bit faults are injected in the bench's RAM model. The bench computes the expected first failure from the fault position and the two sweep values, so faults show up in either sweep. Host writes and repeated starts issued while `busy` is high are then exposed through the run length and a full read-back of the RAM.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic [1:0] {
    P_WR_FWD = 2'd0,
    P_RD_FWD = 2'd1,
    P_WR_INV = 2'd2,
    P_RD_INV = 2'd3
  } pass_t;

  typedef struct packed {
    logic engage;  // engine owns RAM port
    logic wrStb;   // write current word
    logic invert;  // complement sweep
    logic cmpStb;  // compare read data this cycle
    logic clear;   // start accepted: clear result
  } rwb_strobe_t;
endpackage

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
  import rwb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  output rwb_strobe_t       stb,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              busy,
  output logic              donePulse,
  output logic              doneFlag
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [1:0] WR_LAST_SUB = 2'd1;
  localparam logic [1:0] RD_LAST_SUB = 2'd2;

  pass_t      pass;
  logic [1:0] sub;
  logic       readPass;
  logic       launch;
  logic       wordEnd;

  function automatic pass_t nextPass(pass_t p);
    case (p)
      P_WR_FWD: return P_RD_FWD;
      P_RD_FWD: return P_WR_INV;
      P_WR_INV: return P_RD_INV;
      default:  return P_WR_FWD;
    endcase
  endfunction

  always_comb begin
    readPass   = (pass == P_RD_FWD) || (pass == P_RD_INV);
    launch     = startCmd && !busy;
    wordEnd    = (sub == (readPass ? RD_LAST_SUB : WR_LAST_SUB));
    stb.engage = busy;
    stb.wrStb  = busy && !readPass && (sub == 2'd0);
    stb.invert = (pass == P_WR_INV) || (pass == P_RD_INV);
    stb.cmpStb = busy && readPass && (sub == RD_LAST_SUB);
    stb.clear  = launch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pass      <= P_WR_FWD;
      sub       <= 2'd0;
      wordAddr  <= '0;
      busy      <= 1'b0;
      donePulse <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        pass     <= P_WR_FWD;
        sub      <= 2'd0;
        wordAddr <= '0;
        doneFlag <= 1'b0;
      end else if (busy) begin
        if (wordEnd) begin
          sub <= 2'd0;
          if (wordAddr == LAST_ADDR) begin
            wordAddr <= '0;
            if (pass == P_RD_INV) begin
              busy      <= 1'b0;
              donePulse <= 1'b1;
              doneFlag  <= 1'b1;
            end else begin
              pass <= nextPass(pass);
            end
          end else begin
            wordAddr <= wordAddr + 1'b1;
          end
        end else begin
          sub <= sub + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rwb_dpath.sv
module rwb_dpath
  import rwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rwb_strobe_t       stb,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              failFlag,
  output logic [ADDR_W-1:0] diagAddr,
  output logic [DATA_W-1:0] diagExp,
  output logic [DATA_W-1:0] diagAct
);
  logic [DATA_W-1:0] addrWord;
  logic [DATA_W-1:0] expected;
  logic              mismatch;

  always_comb begin
    addrWord               = '0;
    addrWord[ADDR_W-1:0]   = wordAddr;
    expected               = stb.invert ? ~addrWord : addrWord;
    mismatch               = stb.cmpStb && (ramRdata != expected);
    if (stb.engage) begin
      ramEn    = 1'b1;
      ramWe    = stb.wrStb;
      ramAddr  = wordAddr;
      ramWdata = expected;
    end else begin
      ramEn    = hostEn;
      ramWe    = hostEn && hostWe;
      ramAddr  = hostAddr;
      ramWdata = hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      failFlag <= 1'b0;
      diagAddr <= '0;
      diagExp  <= '0;
      diagAct  <= '0;
    end else if (mismatch && !failFlag) begin
      failFlag <= 1'b1;
      diagAddr <= wordAddr;
      diagExp  <= expected;
      diagAct  <= ramRdata;
    end
  end
endmodule

// File: rtl/ram_walk_bist.sv
module ram_walk_bist
  import rwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              busy,
  output logic              donePulse,
  output logic              doneFlag,
  output logic              failFlag,
  output logic [ADDR_W-1:0] diagAddr,
  output logic [DATA_W-1:0] diagExp,
  output logic [DATA_W-1:0] diagAct
);
  rwb_strobe_t       stb;
  logic [ADDR_W-1:0] wordAddr;

  assign hostRdata = ramRdata;

  rwb_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stb(stb),
    .wordAddr(wordAddr), .busy(busy), .donePulse(donePulse),
    .doneFlag(doneFlag)
  );

  rwb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wordAddr(wordAddr),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .ramRdata(ramRdata), .ramEn(ramEn),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .failFlag(failFlag), .diagAddr(diagAddr), .diagExp(diagExp),
    .diagAct(diagAct)
  );
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              busy,
  input logic              donePulse,
  input logic              doneFlag,
  input logic              failFlag,
  input logic              ramWe,
  input logic [ADDR_W-1:0] diagAddr,
  input logic [DATA_W-1:0] diagExp,
  input logic [DATA_W-1:0] diagAct
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startCmd) |=> busy);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r4_pulse_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && doneFlag));

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !startCmd) |=> doneFlag);

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (busy && failFlag) |=> failFlag);

  a_r7_diag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !(startCmd && !busy)) |=>
      ($stable(diagAddr) && $stable(diagExp) && $stable(diagAct)));

  a_r9_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ramWe) |=> !ramWe);
endmodule

bind ram_walk_bist rwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .busy(busy),
  .donePulse(donePulse), .doneFlag(doneFlag), .failFlag(failFlag),
  .ramWe(ramWe), .diagAddr(diagAddr), .diagExp(diagExp), .diagAct(diagAct)
);

// File: tb/sim_ram_walk_bist.sv
module sim_ram_walk_bist;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startCmd = 1'b0;
  logic          hostEn = 1'b0, hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic          ramEn, ramWe;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata;
  logic [DW-1:0] ramRdata = '0;
  logic          busy, donePulse, doneFlag, failFlag;
  logic [AW-1:0] diagAddr;
  logic [DW-1:0] diagExp, diagAct;

  int vectors = 0;
  int miscompares = 0;

  // RAM model with optional stuck bit on one address (read path)
  logic [DW-1:0] mem [N];
  logic          fltOn = 1'b0;
  int            fltBit = 0;
  logic          fltVal = 1'b0;
  logic [AW-1:0] fltAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_walk_bist #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .hostEn(hostEn),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .ramEn(ramEn), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .busy(busy), .donePulse(donePulse), .doneFlag(doneFlag),
    .failFlag(failFlag), .diagAddr(diagAddr), .diagExp(diagExp),
    .diagAct(diagAct)
  );

  function automatic logic [DW-1:0] faulted(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (fltOn && a == fltAddr) r[fltBit] = fltVal;
    return r;
  endfunction

  function automatic logic [DW-1:0] pad(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    r[AW-1:0] = a;
    return r;
  endfunction

  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) mem[ramAddr] <= ramWdata;
      ramRdata <= faulted(ramAddr, mem[ramAddr]);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One full run; interfereCyc/restartCyc < 0 disables that stimulus
  task automatic runTest(int interfereCyc, int restartCyc);
    int cnt = 1;
    logic [DW-1:0] eExp, eAct;
    logic          eFail;
    logic [AW-1:0] eAddr;
    @(negedge clk); startCmd = 1'b1;
    @(negedge clk); startCmd = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R7 diag cleared at start", {diagAddr, diagExp}, 0);
    forever begin
      if (cnt == interfereCyc) begin
        hostEn = 1'b1; hostWe = 1'b1;
        hostAddr = AW'($urandom); hostWdata = DW'($urandom);
      end
      if (cnt == restartCyc) startCmd = 1'b1;
      @(negedge clk);
      hostEn = 1'b0; hostWe = 1'b0; startCmd = 1'b0;
      if (!busy || cnt > 12 * N) break;
      cnt++;
    end
    check("R3 busy length", cnt, 10 * N);
    check("R4 donePulse on completion", donePulse, 1);
    // expected result from the fault model
    eFail = fltOn;
    eAddr = fltOn ? fltAddr : '0;
    eExp = '0; eAct = '0;
    if (fltOn) begin
      if (pad(fltAddr)[fltBit] != fltVal) eExp = pad(fltAddr);
      else eExp = ~pad(fltAddr);
      eAct = eExp;
      eAct[fltBit] = fltVal;
    end
    check("R6 failFlag", failFlag, eFail);
    check("R7 diagAddr", diagAddr, eAddr);
    check("R7 diagExp", diagExp, eExp);
    check("R7 diagAct", diagAct, eAct);
    @(negedge clk);
    check("R4 donePulse one cycle", donePulse, 0);
    check("R4 doneFlag sticky", doneFlag, 1);
    // R5 + R8: full read-back through the host port
    for (int a = 0; a < N; a++) begin
      hostEn = 1'b1; hostWe = 1'b0; hostAddr = AW'(a);
      @(negedge clk);
      check("R5 final RAM word", hostRdata, faulted(AW'(a), ~pad(AW'(a))));
    end
    hostEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    for (int i = 0; i < N; i++) mem[i] = DW'($urandom);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 flags", {donePulse, doneFlag, failFlag}, 0);
    check("R1 diag", {diagAddr, diagExp, diagAct}, 0);

    // R8 idle host write then read
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 8'h3C; hostWdata = 16'hBEEF;
    @(negedge clk);
    hostWe = 1'b0;
    @(negedge clk);
    check("R8 idle host access", hostRdata, 16'hBEEF);
    hostEn = 1'b0;

    // clean run with host interference and a start while busy (R2, R8)
    runTest(777, 1500);

    // directed: stuck-at-1 on bit 15, caught in sweep one (R6, R7)
    fltOn = 1'b1; fltBit = 15; fltVal = 1'b1; fltAddr = 8'h00;
    runTest(-1, -1);
    // directed: stuck-at-0 on bit 15 at last address, caught in sweep two
    fltBit = 15; fltVal = 1'b0; fltAddr = 8'hFF;
    runTest(2000, -1);
    // clean run after failure: diag and fail cleared (R7, R6)
    fltOn = 1'b0;
    runTest(-1, 10);

    // random faults and interference
    for (int k = 0; k < 4; k++) begin
      fltOn   = ($urandom % 4) != 0;
      fltBit  = int'($urandom % DW);
      fltVal  = 1'($urandom);
      fltAddr = AW'($urandom);
      runTest(int'($urandom % (10 * N)) + 1, int'($urandom % (10 * N)) + 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule